// File: doc/BRIEF.md
# Dual-Path Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. Both paths see the same raw level vector, but each has its own enable mask. Software changes a mask only through separate set and clear addresses, so that two agents can never lose each other's update in a read-modify-write race. Raw and masked status are readable for each path. Source 0 can also be raised and dropped by software, so a processor can post an interrupt to itself.

The register bus is word-indexed. One request per cycle is presented on `bus_req`, with `bus_we` choosing write or read. Read data and the error flag come back registered, in the cycle after the request. Because the request outputs are plain levels, the normal request output of one instance can drive a source input of another. In the usual cascade, a secondary controller drives source 26 of the primary one.

The word indexes that software uses are: 0 normal masked status, 1 raw level, 2 normal enable (read, or write-one-to-set), 3 normal enable clear, 4 software source set (a read returns raw bit 0), 5 software source clear, 8 fast masked status, 9 raw level, 10 fast enable (read, or write-one-to-set), 11 fast enable clear.

Top module: `dual_path_intc`

## Requirements
- R1: Raw level bit i is the value of source line i. Bit 0 is also set while the software latch is set. Reads of index 1 or index 9 return the raw level vector.
- R2: A write to index 2 ORs the written word into the normal enable mask. A write to index 3 clears the bits that are 1 in the written word. A read of index 2 returns the normal enable mask.
- R3: A write to index 10 ORs the written word into the fast enable mask. A write to index 11 clears the bits that are 1 in the written word. A read of index 10 returns the fast enable mask.
- R4: A read of index 0 returns the raw level ANDed with the normal mask. A read of index 8 returns the raw level ANDed with the fast mask.
- R5: A write to index 4 with bit 0 set sets the software latch. A write to index 5 with bit 0 set clears it. A write to either index with bit 0 clear changes nothing. A read of index 4 returns raw level bit 0 in bit 0 and zeros in every other bit.
- R6: `irq_o` is a register that is 1 when the raw level ANDed with the normal mask is non-zero. It updates one clock after a source change or a register write.
- R7: `fiq_o` is a register that is 1 when the raw level ANDed with the fast mask is non-zero. It follows the same one-clock timing as `irq_o`.
- R8: A read of index 3, 5 or 11, or of any index other than 0, 1, 2, 4, 8, 9 or 10, returns zero and raises `bus_err` for exactly that response cycle. It changes no state.
- R9: Writes to indexes 0, 1, 8 and 9, and to every unmapped index, are ignored and do not raise `bus_err`.
- R10: After a synchronous reset, both enable masks and the software latch are zero, `irq_o` and `fiq_o` are low, and `bus_rdata` and `bus_err` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level-sensitive interrupt source lines |
| bus_req | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_idx | input | IDX_W | Word index of the register |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data, valid the cycle after a read |
| bus_err | output | 1 | Bad read flag, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Each result has its own timing. A write or a source change is reflected on `irq_o` and `fiq_o` after the very next rising edge. Read data and `bus_err` appear after the edge that accepts the read, and they reflect the state and source lines held during that cycle. The bench drives every stimulus on the falling edge and samples one nanosecond after the following rising edge. It updates its own model of the masks and the latch at that edge and compares the outputs in that window. Expected read data is computed from the model before the update, because a read returns the state as it stood when the request was accepted.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int IX_IRQ_STAT = 0;
    localparam int IX_RAW_A    = 1;
    localparam int IX_IRQ_EN   = 2;
    localparam int IX_IRQ_CLR  = 3;
    localparam int IX_SW_SET   = 4;
    localparam int IX_SW_CLR   = 5;
    localparam int IX_FIQ_STAT = 8;
    localparam int IX_RAW_B    = 9;
    localparam int IX_FIQ_EN   = 10;
    localparam int IX_FIQ_CLR  = 11;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_IRQ_SET,
        WOP_IRQ_CLR,
        WOP_SW_SET,
        WOP_SW_CLR,
        WOP_FIQ_SET,
        WOP_FIQ_CLR
    } wr_op_e;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_IRQ_STAT,
        RSEL_RAW,
        RSEL_IRQ_EN,
        RSEL_SW,
        RSEL_FIQ_STAT,
        RSEL_FIQ_EN,
        RSEL_BAD
    } rd_sel_e;

    typedef struct packed {
        wr_op_e  wop;
        rd_sel_e rsel;
    } access_t;

    function automatic wr_op_e wr_lookup(input int ix);
        case (ix)
            IX_IRQ_EN:  return WOP_IRQ_SET;
            IX_IRQ_CLR: return WOP_IRQ_CLR;
            IX_SW_SET:  return WOP_SW_SET;
            IX_SW_CLR:  return WOP_SW_CLR;
            IX_FIQ_EN:  return WOP_FIQ_SET;
            IX_FIQ_CLR: return WOP_FIQ_CLR;
            default:    return WOP_NONE;
        endcase
    endfunction

    function automatic rd_sel_e rd_lookup(input int ix);
        case (ix)
            IX_IRQ_STAT:        return RSEL_IRQ_STAT;
            IX_RAW_A, IX_RAW_B: return RSEL_RAW;
            IX_IRQ_EN:          return RSEL_IRQ_EN;
            IX_SW_SET:          return RSEL_SW;
            IX_FIQ_STAT:        return RSEL_FIQ_STAT;
            IX_FIQ_EN:          return RSEL_FIQ_EN;
            default:            return RSEL_BAD;
        endcase
    endfunction

endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import intc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             req_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    output access_t          acc_o
);
    always_comb begin
        acc_o.wop  = WOP_NONE;
        acc_o.rsel = RSEL_NONE;
        if (req_i) begin
            if (we_i) acc_o.wop  = wr_lookup(int'(idx_i));
            else      acc_o.rsel = rd_lookup(int'(idx_i));
        end
    end
endmodule

// File: rtl/intc_mask.sv
module intc_mask #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] mask_d,
    output logic [N-1:0] mask_q
);
    always_comb begin
        mask_d = mask_q;
        if (set_i)      mask_d = mask_q | bits_i;
        else if (clr_i) mask_d = mask_q & ~bits_i;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    // R2 / R3: set and clear take effect, and the mask holds otherwise
    p_mask_set_r2_r3: assert property (@(posedge clk) disable iff (rst)
        set_i |=> ((mask_q & $past(bits_i)) == $past(bits_i)));
    p_mask_clr_r2_r3: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((mask_q & $past(bits_i)) == '0));
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(mask_q));
endmodule

// File: rtl/intc_soft_src.sv
module intc_soft_src (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic bit0_i,
    output logic sw_d,
    output logic sw_q
);
    always_comb begin
        sw_d = sw_q;
        if (set_i && bit0_i)      sw_d = 1'b1;
        else if (clr_i && bit0_i) sw_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) sw_q <= 1'b0;
        else     sw_q <= sw_d;
    end

    // R5: the latch responds only to bit 0 of the written word
    p_sw_set_r5: assert property (@(posedge clk) disable iff (rst)
        (set_i && bit0_i) |=> sw_q);
    p_sw_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && bit0_i) |=> !sw_q);
    p_sw_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !bit0_i |=> $stable(sw_q));
endmodule

// File: rtl/intc_readback.sv
module intc_readback
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  rd_sel_e      rsel_i,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] irq_en_i,
    input  logic [N-1:0] fiq_en_i,
    output logic [N-1:0] rdata_q,
    output logic         err_q
);
    logic [N-1:0] rdata_d;

    always_comb begin
        case (rsel_i)
            RSEL_IRQ_STAT: rdata_d = level_i & irq_en_i;
            RSEL_RAW:      rdata_d = level_i;
            RSEL_IRQ_EN:   rdata_d = irq_en_i;
            RSEL_SW:       rdata_d = {{(N-1){1'b0}}, level_i[0]};
            RSEL_FIQ_STAT: rdata_d = level_i & fiq_en_i;
            RSEL_FIQ_EN:   rdata_d = fiq_en_i;
            default:       rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rdata_d;
            err_q   <= (rsel_i == RSEL_BAD);
        end
    end

    // R8: a flagged response never carries data
    p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (rdata_q == '0));
    // R8: the flag lasts only for the response to a bad read
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (rsel_i != RSEL_BAD) |=> !err_q);
endmodule

// File: rtl/dual_path_intc.sv
module dual_path_intc
    import intc_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [N_SRC-1:0] bus_wdata,
    output logic [N_SRC-1:0] bus_rdata,
    output logic             bus_err,
    output logic             irq_o,
    output logic             fiq_o
);
    localparam int PAD_W = N_SRC - 1;

    access_t          acc;
    logic [N_SRC-1:0] irq_en_d, irq_en_q, fiq_en_d, fiq_en_q;
    logic             sw_d, sw_q;
    logic [N_SRC-1:0] level_now, level_next;

    intc_decode #(.IDX_W(IDX_W)) u_dec (
        .req_i (bus_req),
        .we_i  (bus_we),
        .idx_i (bus_idx),
        .acc_o (acc)
    );

    intc_mask #(.N(N_SRC)) u_irq_mask (
        .clk    (clk),
        .rst    (rst),
        .set_i  (acc.wop == WOP_IRQ_SET),
        .clr_i  (acc.wop == WOP_IRQ_CLR),
        .bits_i (bus_wdata),
        .mask_d (irq_en_d),
        .mask_q (irq_en_q)
    );

    intc_mask #(.N(N_SRC)) u_fiq_mask (
        .clk    (clk),
        .rst    (rst),
        .set_i  (acc.wop == WOP_FIQ_SET),
        .clr_i  (acc.wop == WOP_FIQ_CLR),
        .bits_i (bus_wdata),
        .mask_d (fiq_en_d),
        .mask_q (fiq_en_q)
    );

    intc_soft_src u_soft (
        .clk    (clk),
        .rst    (rst),
        .set_i  (acc.wop == WOP_SW_SET),
        .clr_i  (acc.wop == WOP_SW_CLR),
        .bit0_i (bus_wdata[0]),
        .sw_d   (sw_d),
        .sw_q   (sw_q)
    );

    assign level_now  = src_i | {{PAD_W{1'b0}}, sw_q};
    assign level_next = src_i | {{PAD_W{1'b0}}, sw_d};

    intc_readback #(.N(N_SRC)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rsel_i   (acc.rsel),
        .level_i  (level_now),
        .irq_en_i (irq_en_q),
        .fiq_en_i (fiq_en_q),
        .rdata_q  (bus_rdata),
        .err_q    (bus_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(level_next & irq_en_d);
            fiq_o <= |(level_next & fiq_en_d);
        end
    end

    // R6 / R7: each output matches the source lines of the previous cycle, combined with the current latch and masks
    p_irq_track_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(($past(src_i) | {{PAD_W{1'b0}}, sw_q}) & irq_en_q));
    p_fiq_track_r7: assert property (@(posedge clk) disable iff (rst)
        fiq_o == |(($past(src_i) | {{PAD_W{1'b0}}, sw_q}) & fiq_en_q));
    // R10: outputs are quiet right after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && !fiq_o && !bus_err && bus_rdata == '0));
    // R9: a write never produces an error response
    p_write_no_err_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> !bus_err);
endmodule

// File: tb/sim_dual_path_intc.sv
`timescale 1ns/1ps
module sim_dual_path_intc;
    localparam int N = 32;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  src_i;
    logic          bus_req, bus_we;
    logic [IW-1:0] bus_idx;
    logic [N-1:0]  bus_wdata;
    logic [N-1:0]  bus_rdata;
    logic          bus_err, irq_o, fiq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [N-1:0] m_ie = '0, m_fe = '0;
    logic         m_sw = 1'b0;

    always #2.5 clk = ~clk;

    dual_path_intc #(.N_SRC(N), .IDX_W(IW)) u0 (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_req(bus_req), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [N-1:0] lvl(input logic [N-1:0] s);
        return s | {{(N-1){1'b0}}, m_sw};
    endfunction

    function automatic bit bad_rd(input int i);
        return !(i inside {0, 1, 2, 4, 8, 9, 10});
    endfunction

    function automatic logic [N-1:0] exp_rd(input int i, input logic [N-1:0] s);
        case (i)
            0:    return lvl(s) & m_ie;
            1, 9: return lvl(s);
            2:    return m_ie;
            4:    return {{(N-1){1'b0}}, lvl(s)[0]};
            8:    return lvl(s) & m_fe;
            10:   return m_fe;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string r, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic op(input bit we, input int i, input logic [N-1:0] d, input logic [N-1:0] s);
        logic [N-1:0] erd;
        bit           eerr;
        @(negedge clk);
        src_i = s; bus_req = 1'b1; bus_we = we; bus_idx = IW'(i); bus_wdata = d;
        erd  = exp_rd(i, s);
        eerr = !we && bad_rd(i);
        @(posedge clk);
        #1;
        bus_req = 1'b0;
        if (we) begin
            case (i)
                2:  m_ie = m_ie | d;
                3:  m_ie = m_ie & ~d;
                4:  if (d[0]) m_sw = 1'b1;
                5:  if (d[0]) m_sw = 1'b0;
                10: m_fe = m_fe | d;
                11: m_fe = m_fe & ~d;
                default: ;
            endcase
            chk(i inside {0, 1, 8, 9} || i > 11 ? "R9 write err" : "R2/R3/R5 write err",
                N'(bus_err), '0);
        end else begin
            chk(eerr ? "R8 bad read data" : "R1/R2/R3/R4/R5 read data", bus_rdata, erd);
            chk(eerr ? "R8 err flag" : "R8 no err flag", N'(bus_err), N'(eerr));
        end
        chk("R6 irq_o", N'(irq_o), N'(|(lvl(s) & m_ie)));
        chk("R7 fiq_o", N'(fiq_o), N'(|(lvl(s) & m_fe)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; src_i = '0; bus_req = 1'b0; bus_we = 1'b0; bus_idx = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 rdata", bus_rdata, '0);
        chk("R10 err", N'(bus_err), '0);
        chk("R10 irq/fiq", N'({irq_o, fiq_o}), '0);
        @(negedge clk); rst = 1'b0;

        // R10: masks and latch read back as zero
        op(0, 2, '0, 32'hFFFF_FFFF);
        op(0, 10, '0, 32'hFFFF_FFFF);
        op(0, 4, '0, '0);
        // R2 / R6: enable one source, then clear it
        op(1, 2, 32'h0000_0100, 32'h0000_0100);
        op(0, 0, '0, 32'h0000_0100);
        op(1, 3, 32'h0000_0100, 32'h0000_0100);
        // R1: the source drops while the mask is set
        op(1, 2, 32'h0400_0000, 32'h0400_0000);
        op(0, 1, '0, 32'h0000_0000);
        // R3 / R7: fast path, the cascade source 26
        op(1, 10, 32'h0400_0000, 32'h0400_0000);
        op(0, 8, '0, 32'h0400_0000);
        op(1, 11, 32'h0400_0000, 32'h0400_0000);
        // R5: bit 0 clear does nothing; bit 0 set raises source 0
        op(1, 4, 32'hFFFF_FFFE, '0);
        op(0, 4, '0, 32'hF000_0000);
        op(1, 2, 32'h0000_0001, '0);
        op(1, 4, 32'h0000_0001, '0);
        op(0, 4, '0, 32'hF000_0000);
        op(1, 5, 32'hFFFF_FFFE, '0);
        op(0, 9, '0, '0);
        op(1, 5, 32'h0000_0001, '0);
        // R8: bad reads, then the state is unchanged
        op(0, 3, '0, 32'h1);
        op(0, 5, '0, 32'h1);
        op(0, 11, '0, 32'h1);
        op(0, 63, '0, 32'h1);
        op(0, 2, '0, 32'h1);
        // R9: writes to status or unmapped indexes are ignored
        op(1, 0, 32'hFFFF_FFFF, '0);
        op(1, 1, 32'hFFFF_FFFF, '0);
        op(1, 8, 32'hFFFF_FFFF, '0);
        op(1, 9, 32'hFFFF_FFFF, '0);
        op(1, 40, 32'hFFFF_FFFF, '0);
        op(0, 2, '0, '0);
        op(0, 10, '0, '0);

        for (int k = 0; k < 600; k++) begin
            int i;
            i = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 12);
            op(1'($urandom), i, $urandom & $urandom, $urandom & $urandom & $urandom);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule